// File: doc/BRIEF.md
# Sliced Arithmetic/Logic Unit with Flags

This block is a purely combinational arithmetic/logic unit for two operands of a parameterised width (32 bits by default). It is built as a chain of identical one-bit slices. Each slice holds a full adder and a small selector that picks the slice's result bit. A two-bit function code chooses one of four things: the adder, the bitwise inverse of the second operand, a bitwise OR, or a bitwise AND. When the adder is chosen, a separate subtract bit picks a sum or a difference.

Subtraction reuses the adder. Each bit of the second operand is inverted before it enters its slice, and the carry into the lowest slice is forced to one. Two flags come out beside the result. The first reports signed two's-complement overflow of the add or subtract. The second is high whenever any result bit is set. A surrounding datapath can use that second flag as a branch condition.

Top module: `alu_sliced`

## Requirements
- R1: With `func` = 0 and `do_sub` = 0, `result` equals `op_a + op_b` modulo 2^WIDTH.
- R2: With `func` = 0 and `do_sub` = 1, `result` equals `op_a - op_b` modulo 2^WIDTH, formed by adding the inverted `op_b` to `op_a` with a carry-in of 1.
- R3: With `func` = 1, `result` equals the bitwise inverse of `op_b`, whatever the values of `op_a` and `do_sub`.
- R4: With `func` = 2, `result` equals the bitwise OR of `op_a` and `op_b`.
- R5: With `func` = 3, `result` equals the bitwise AND of `op_a` and `op_b`.
- R6: With `func` = 0, `ovf` is 1 exactly when the signed two's-complement result of the selected add or subtract does not fit in WIDTH bits. This happens for 0x7FFFFFFF + 1 and for 0x80000000 - 1 at the default width.
- R7: With `func` other than 0, `ovf` is 0.
- R8: `nonzero` is 1 exactly when at least one bit of `result` is 1, under every function code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| func | input | 2 | Function code: 0 adder, 1 NOT of op_b, 2 OR, 3 AND |
| do_sub | input | 1 | With func 0: 1 subtracts, 0 adds |
| result | output | WIDTH | Selected result |
| ovf | output | 1 | Signed overflow of the add or subtract |
| nonzero | output | 1 | High when any result bit is 1 |

## Verification
The embedded checks assume that all four inputs carry known 0/1 values. Each check is skipped while any input is unknown. The checks also assume that inputs change only as a group, and that the ripple chain has settled before its outputs are judged.

The bench drives every input together, one clock phase before it samples. Its stimulus is a set of directed corner cases: zero, all ones, the most negative value, and the largest positive value. These are followed by pseudo-random operands and function codes, so the signed overflow boundaries are reached from both directions.

// File: rtl/alu_sliced.sv
module alu_sliced #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic [1:0]       func,
  input  logic             do_sub,
  output logic [WIDTH-1:0] result,
  output logic             ovf,
  output logic             nonzero
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH:0] carry;
  assign carry[0] = do_sub;

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    logic bx, sum;
    assign bx           = op_b[i] ^ do_sub;
    assign sum          = op_a[i] ^ bx ^ carry[i];
    assign carry[i+1]   = (op_a[i] & bx) | (carry[i] & (op_a[i] ^ bx));
    assign result[i]    = (func == 2'd0) ? sum :
                          (func == 2'd1) ? ~op_b[i] :
                          (func == 2'd2) ? (op_a[i] | op_b[i]) :
                                           (op_a[i] & op_b[i]);
  end

  assign ovf     = (func == 2'd0) & (carry[WIDTH] ^ carry[MSB]);
  assign nonzero = |result;

  always_comb begin
    if (!$isunknown({op_a, op_b, func, do_sub})) begin
      if (func == 2'd0 && !do_sub)
        p_add_r1: assert (result == op_a + op_b) else $error("R1 add mismatch");
      if (func == 2'd0 && do_sub)
        p_sub_r2: assert (result == op_a - op_b) else $error("R2 sub mismatch");
      if (func == 2'd1)
        p_not_r3: assert (result == ~op_b) else $error("R3 not mismatch");
      if (func == 2'd2)
        p_or_r4: assert (result == (op_a | op_b)) else $error("R4 or mismatch");
      if (func == 2'd3)
        p_and_r5: assert (result == (op_a & op_b)) else $error("R5 and mismatch");
      if (func == 2'd0 && !do_sub)
        p_add_ovf_r6: assert (ovf == ((op_a[MSB] == op_b[MSB]) && (result[MSB] != op_a[MSB])))
          else $error("R6 add overflow mismatch");
      if (func == 2'd0 && do_sub)
        p_sub_ovf_r6: assert (ovf == ((op_a[MSB] != op_b[MSB]) && (result[MSB] != op_a[MSB])))
          else $error("R6 sub overflow mismatch");
      if (func != 2'd0)
        p_no_overflow_r7: assert (!ovf) else $error("R7 overflow in logic mode");
      p_nonzero_r8: assert (nonzero == (result != '0)) else $error("R8 nonzero mismatch");
    end
  end
endmodule

// File: tb/test_alu_sliced.sv
module test_alu_sliced;
  localparam int W = 32;
  localparam longint MAXP = 64'sd2147483647;
  localparam longint MINN = -64'sd2147483648;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [W-1:0] a = '0, b = '0;
  logic [1:0]   f = 2'd0;
  logic         s = 1'b0;
  logic [W-1:0] res;
  logic         ovf, nz;

  int checks = 0, fails = 0;
  bit finished = 0;

  alu_sliced #(.WIDTH(W)) i_alu_sliced (
    .op_a(a), .op_b(b), .func(f), .do_sub(s),
    .result(res), .ovf(ovf), .nonzero(nz)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s a=%h b=%h f=%0d s=%0b actual=%h expected=%h", tag, a, b, f, s, act, exp);
    end
  endtask

  task automatic run(input logic [W-1:0] va, input logic [W-1:0] vb,
                     input logic [1:0] vf, input logic vs);
    longint sa, sb, full;
    logic [W-1:0] er;
    logic eo;
    string rtag, otag;
    @(posedge clk); #1;
    a = va; b = vb; f = vf; s = vs;
    sa = longint'($signed(va));
    sb = longint'($signed(vb));
    eo = 1'b0;
    case (vf)
      2'd0: begin
        full = vs ? sa - sb : sa + sb;
        er   = W'(full);
        eo   = (full > MAXP) || (full < MINN);
        rtag = vs ? "R2" : "R1";
      end
      2'd1: begin er = ~vb;     rtag = "R3"; end
      2'd2: begin er = va | vb; rtag = "R4"; end
      default: begin er = va & vb; rtag = "R5"; end
    endcase
    otag = (vf == 2'd0) ? "R6" : "R7";
    @(negedge clk);
    chk(rtag, res, er);
    chk(otag, W'(ovf), W'(eo));
    chk("R8", W'(nz), W'(er != '0));
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R8", W'(nz), W'(0));
    chk("R1", res, '0);
    rst_n = 1'b1;
    run(32'h7FFFFFFF, 32'h1, 2'd0, 1'b0);
    run(32'h80000000, 32'h1, 2'd0, 1'b1);
    run(32'h80000000, 32'h80000000, 2'd0, 1'b0);
    run(32'hFFFFFFFF, 32'hFFFFFFFF, 2'd0, 1'b0);
    run(32'h0, 32'h80000000, 2'd0, 1'b1);
    run(32'h12345678, 32'h12345678, 2'd0, 1'b1);
    run(32'h0, 32'h0, 2'd0, 1'b0);
    run(32'hDEADBEEF, 32'hFFFFFFFF, 2'd1, 1'b1);
    run(32'h0, 32'hFFFFFFFF, 2'd1, 1'b0);
    run(32'hFFFFFFFF, 32'h0, 2'd2, 1'b0);
    run(32'h0, 32'h0, 2'd2, 1'b1);
    run(32'hFFFFFFFF, 32'h80000000, 2'd3, 1'b0);
    run(32'hAAAAAAAA, 32'h55555555, 2'd3, 1'b1);
    run(32'h7FFFFFFF, 32'hFFFFFFFF, 2'd2, 1'b0);
    for (int k = 0; k < 3000; k++)
      run($urandom, $urandom, 2'($urandom), 1'($urandom));
    summary();
  end
endmodule